// File: doc/BRIEF.md
# I2C Transmit Command Queue

This block is the transmit-side queue between a host register port and an I2C master engine. The host pushes one 32-bit word per write. The word holds a data byte and two control flags: begin-transfer and end-transfer. The queue keeps up to sixteen such entries. It hands them to the engine one at a time, in arrival order, over a valid/ready port.

Each entry is decoded while it sits at the head of the queue. The engine's current state decides the meaning of the flags. A begin-transfer flag becomes a fresh start condition while the engine is idle, and a repeated start while the engine already owns the bus. An end-transfer flag always asks for a stop condition. When the engine is acting as a master receiver, the same flag also marks the byte as a count of bytes to receive, not as a byte to send.

The host can read back the byte at the head without removing it. It can also see the fill level and the full and empty status. A flush input empties the queue, so that entries left behind by an aborted transfer can be thrown away before a new one begins.

Top module: `i2c_txcmd_fifo`

## Requirements
- R1: An accepted write stores one entry and raises `level` by one. `empty` is 1 exactly when `level` is 0, and `full` is 1 exactly when `level` is 16.
- R2: A write while `full` is 1 is discarded. The level stays 16 and the stored entries and their order are unchanged.
- R3: `rd_word[7:0]` shows the head byte and `rd_word[31:8]` reads as zero. The flag bits never appear there. Reading does not remove the entry.
- R4: A write word carries the byte in bits 7:0, the begin flag in bit 8 and the end flag in bit 9. For a head entry with the begin flag, `cmd_kind` is 1 (start) when `master_active` is 0 and 2 (repeated start) when it is 1. Without the flag, `cmd_kind` is 0.
- R5: A head entry with the end flag drives `cmd_stop` to 1. `cmd_is_count` is 1 only when the end flag is set and `rx_mode` is 1, and the byte is then the receive count.
- R6: `cmd_valid` equals not-empty. Each cycle with `cmd_valid` and `cmd_ready` both 1 removes one entry. Entries leave in the order they were written.
- R7: `flush` leaves the queue empty after the next clock edge. It wins over a write or a removal in the same cycle.
- R8: After reset `level` is 0, `empty` is 1 and `cmd_valid` is 0. `rd_word[7:0]` keeps the byte it showed before the reset.
- R9: Write bits 31:10 have no effect on the stored byte or on the decoded command.
- R10: A write and a removal in the same cycle on a non-full queue leave `level` unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Host write strobe for the queue address |
| wr_data | input | 32 | Write word: byte [7:0], begin flag [8], end flag [9] |
| flush | input | 1 | Empty the queue |
| rd_word | output | 32 | Head byte, zero-extended |
| level | output | 5 | Number of stored entries, 0 to 16 |
| full | output | 1 | Queue holds 16 entries |
| empty | output | 1 | Queue holds no entry |
| master_active | input | 1 | Engine currently owns the bus as master |
| rx_mode | input | 1 | Engine is acting as master receiver |
| cmd_valid | output | 1 | Head entry offered to the engine |
| cmd_ready | input | 1 | Engine takes the head entry |
| cmd_kind | output | 2 | 0 none, 1 start, 2 repeated start |
| cmd_stop | output | 1 | Stop condition requested after this byte |
| cmd_is_count | output | 1 | Byte is a receive count |
| cmd_byte | output | 8 | Head byte for the engine |

## Verification
Some properties hold every cycle, and the assertions check these. They cover the link between level and the full and empty flags, `cmd_valid` tracking not-empty, a flush emptying the queue at once, a full queue staying full until something is removed, a balanced write and removal keeping the level, and the head byte holding steady while nothing is removed. Other behaviour needs a known sequence of writes, so only the bench scenarios show it. This covers first-in first-out order across a full fill and drain, the decoding of each flag combination against the engine state, reserved bits being ignored, a discarded overflow byte never reaching the output, and the head byte surviving a reset.

// File: rtl/i2c_txq_pkg.sv
// Package: shared constants and types for the I2C transmit command queue.
// Assumes a 32-bit host word with the byte in the low bits and two flag bits above it.
package i2c_txq_pkg;
    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int BEGIN_POS = 8;
    localparam int END_POS   = 9;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_START   = 2'd1,
        KIND_RESTART = 2'd2
    } start_kind_e;

    typedef struct packed {
        logic              begin_f;
        logic              end_f;
        logic [BYTE_W-1:0] data;
    } q_entry_t;
endpackage

// File: rtl/i2c_txq_store.sv
// Module: circular storage with pointers, fill count and a registered head byte.
// Assumes push and pop requests are qualified here against full, empty and flush.
// The byte array and the head register carry no reset, so the head byte survives reset.
// The per-entry flags are reset to zero.
module i2c_txq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic                         flush_i,
    input  logic [DW-1:0]                wr_byte_i,
    input  logic                         wr_begin_i,
    input  logic                         wr_end_i,
    output logic [DW-1:0]                head_byte_o,
    output logic                         head_begin_o,
    output logic                         head_end_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic                         full_o,
    output logic                         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] wr_ptr, rd_ptr, rd_next;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;
    logic [DW-1:0] mem [DEPTH];
    logic [DEPTH-1:0] begin_q, end_q;
    logic [DW-1:0] head_q;

    // Qualify requests: flush wins, a full queue rejects, an empty one cannot pop.
    assign push_ok = push_i && !full_o && !flush_i;
    assign pop_ok  = pop_i && !empty_o && !flush_i;
    assign rd_next = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;

    // Status from the fill count.
    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign level_o = count;

    // Byte array write, no reset on purpose.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wr_byte_i;
    end

    // Per-entry flag registers, cleared by reset.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                begin_q[g] <= 1'b0;
                end_q[g]   <= 1'b0;
            end else if (push_ok && wr_ptr == AW'(g)) begin
                begin_q[g] <= wr_begin_i;
                end_q[g]   <= wr_end_i;
            end
        end
    end

    // Pointer and count update, flush restarts both pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_next;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head byte register: loads the byte that becomes the head, otherwise holds.
    always_ff @(posedge clk) begin
        if (push_ok && (empty_o || (pop_ok && count == CW'(1))))
            head_q <= wr_byte_i;
        else if (pop_ok && count > CW'(1))
            head_q <= mem[rd_next];
    end

    assign head_byte_o  = head_q;
    assign head_begin_o = begin_q[rd_ptr] && !empty_o;
    assign head_end_o   = end_q[rd_ptr] && !empty_o;
endmodule

// File: rtl/i2c_txq_decode.sv
// Module: turns the head entry into a tagged command for the master engine.
// Assumes master_active and rx_mode are stable engine state while an entry waits.
module i2c_txq_decode
    import i2c_txq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          empty_i,
    input  logic [DW-1:0] head_byte_i,
    input  logic          head_begin_i,
    input  logic          head_end_i,
    input  logic          master_active_i,
    input  logic          rx_mode_i,
    output logic          cmd_valid_o,
    output start_kind_e   cmd_kind_o,
    output logic          cmd_stop_o,
    output logic          cmd_is_count_o,
    output logic [DW-1:0] cmd_byte_o
);
    // Classify the begin flag against the engine's bus ownership.
    always_comb begin
        if (!head_begin_i)        cmd_kind_o = KIND_NONE;
        else if (master_active_i) cmd_kind_o = KIND_RESTART;
        else                      cmd_kind_o = KIND_START;
    end

    assign cmd_valid_o    = !empty_i;
    assign cmd_stop_o     = head_end_i;
    assign cmd_is_count_o = head_end_i && rx_mode_i;
    assign cmd_byte_o     = head_byte_i;
endmodule

// File: rtl/i2c_txcmd_fifo.sv
// Module: top of the I2C transmit command queue.
// It splits host words into byte and flags, stores them, exposes head readback
// and status, and offers the decoded head entry to the engine.
// Assumes one host write per wr_valid cycle, and that the host honours full.
module i2c_txcmd_fifo
    import i2c_txq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              flush,
    output logic [BUS_W-1:0]  rd_word,
    output logic [CW-1:0]     level,
    output logic              full,
    output logic              empty,
    input  logic              master_active,
    input  logic              rx_mode,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_kind,
    output logic              cmd_stop,
    output logic              cmd_is_count,
    output logic [BYTE_W-1:0] cmd_byte
);
    q_entry_t    wr_entry;
    logic [BYTE_W-1:0] head_byte;
    logic        head_begin, head_end;
    start_kind_e kind;
    logic        unused_reserved;

    // Field split of the host word; reserved bits are dropped.
    assign wr_entry.data    = wr_data[BYTE_W-1:0];
    assign wr_entry.begin_f = wr_data[BEGIN_POS];
    assign wr_entry.end_f   = wr_data[END_POS];
    assign unused_reserved  = ^wr_data[BUS_W-1:END_POS+1];

    i2c_txq_store #(.DEPTH(DEPTH), .DW(BYTE_W)) store_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (wr_valid),
        .pop_i        (cmd_ready),
        .flush_i      (flush),
        .wr_byte_i    (wr_entry.data),
        .wr_begin_i   (wr_entry.begin_f),
        .wr_end_i     (wr_entry.end_f),
        .head_byte_o  (head_byte),
        .head_begin_o (head_begin),
        .head_end_o   (head_end),
        .level_o      (level),
        .full_o       (full),
        .empty_o      (empty)
    );

    i2c_txq_decode #(.DW(BYTE_W)) decode_i (
        .empty_i         (empty),
        .head_byte_i     (head_byte),
        .head_begin_i    (head_begin),
        .head_end_i      (head_end),
        .master_active_i (master_active),
        .rx_mode_i       (rx_mode),
        .cmd_valid_o     (cmd_valid),
        .cmd_kind_o      (kind),
        .cmd_stop_o      (cmd_stop),
        .cmd_is_count_o  (cmd_is_count),
        .cmd_byte_o      (cmd_byte)
    );

    // Readback: byte only, flag positions and above read as zero.
    assign rd_word  = {{(BUS_W-BYTE_W){1'b0}}, head_byte};
    assign cmd_kind = kind;
endmodule

// File: rtl/i2c_txq_chk.sv
// Module: assertion checker for the transmit command queue, bound to the top.
// Assumes a synchronous active-low reset and observes top-level ports only.
module i2c_txq_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          flush,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [CW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic [31:0]   rd_word
);
    // R1
    status_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (level == '0)) && (full == (level == CW'(DEPTH))));
    // R2
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !flush && !(cmd_valid && cmd_ready) |=> full);
    // R3
    head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !empty && !flush && !(cmd_valid && cmd_ready) |=> $stable(rd_word));
    // R6
    valid_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid == !empty);
    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty && level == '0);
    // R10
    level_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !full && !flush && cmd_valid && cmd_ready |=> $stable(level));
endmodule

bind i2c_txcmd_fifo i2c_txq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .flush     (flush),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .rd_word   (rd_word)
);

// File: tb/i2c_txcmd_fifo_tb_top.sv
`timescale 1ns/1ps
module i2c_txcmd_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        flush = 1'b0;
    logic [31:0] rd_word;
    logic [4:0]  level;
    logic        full, empty;
    logic        master_active = 1'b0;
    logic        rx_mode = 1'b0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [1:0]  cmd_kind;
    logic        cmd_stop, cmd_is_count;
    logic [7:0]  cmd_byte;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    i2c_txcmd_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .flush(flush), .rd_word(rd_word), .level(level), .full(full),
        .empty(empty), .master_active(master_active), .rx_mode(rx_mode),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_stop(cmd_stop), .cmd_is_count(cmd_is_count), .cmd_byte(cmd_byte)
    );

    // Vector: {word, master_active, rx_mode, exp byte, exp kind, exp stop, exp count}
    localparam int NV = 8;
    localparam logic [45:0] VEC [NV] = '{
        {32'h0000_0155, 1'b0, 1'b0, 8'h55, 2'd1, 1'b0, 1'b0},
        {32'h0000_0155, 1'b1, 1'b0, 8'h55, 2'd2, 1'b0, 1'b0},
        {32'h0000_00A3, 1'b1, 1'b1, 8'hA3, 2'd0, 1'b0, 1'b0},
        {32'h0000_0204, 1'b1, 1'b1, 8'h04, 2'd0, 1'b1, 1'b1},
        {32'h0000_0204, 1'b1, 1'b0, 8'h04, 2'd0, 1'b1, 1'b0},
        {32'h0000_03C7, 1'b1, 1'b1, 8'hC7, 2'd2, 1'b1, 1'b1},
        {32'hFFFF_FC3E, 1'b0, 1'b1, 8'h3E, 2'd0, 1'b0, 1'b0},
        {32'hABCD_E1F0, 1'b0, 1'b0, 8'hF0, 2'd1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock with the given controls, then sample at the falling edge.
    task automatic cycle(input logic wv, input logic [31:0] wd, input logic rdy, input logic fl);
        wr_valid = wv; wr_data = wd; cmd_ready = rdy; flush = fl;
        @(negedge clk);
        wr_valid = 1'b0; cmd_ready = 1'b0; flush = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 level", 32'(level), 0);
        check("R8 empty", 32'(empty), 1);
        check("R8 cmd_valid", 32'(cmd_valid), 0);
        check("R1 full", 32'(full), 0);

        // Table of single-entry decodes: R3 R4 R5 R9
        for (int i = 0; i < NV; i++) begin
            master_active = VEC[i][13];
            rx_mode       = VEC[i][12];
            cycle(1'b1, VEC[i][45:14], 1'b0, 1'b0);
            check("R1 level", 32'(level), 1);
            check("R3 rd_word", rd_word, {24'h0, VEC[i][11:4]});
            check("R9 cmd_byte", 32'(cmd_byte), 32'(VEC[i][11:4]));
            check("R4 cmd_kind", 32'(cmd_kind), 32'(VEC[i][3:2]));
            check("R5 cmd_stop", 32'(cmd_stop), 32'(VEC[i][1]));
            check("R5 cmd_is_count", 32'(cmd_is_count), 32'(VEC[i][0]));
            cycle(1'b0, '0, 1'b1, 1'b0);
            check("R6 empty after pop", 32'(empty), 1);
        end
        master_active = 1'b0; rx_mode = 1'b0;

        // Fill to capacity in order: R1
        for (int i = 0; i < 16; i++) cycle(1'b1, 32'h10 + 32'(i), 1'b0, 1'b0);
        check("R1 level full", 32'(level), 16);
        check("R1 full flag", 32'(full), 1);
        // R3 reading does not remove
        check("R3 head", rd_word, 32'h10);
        check("R3 no pop", 32'(level), 16);
        // R2 overflow discarded
        cycle(1'b1, 32'h0000_03EE, 1'b0, 1'b0);
        check("R2 level", 32'(level), 16);
        check("R2 head", rd_word, 32'h10);
        // Drain and check order: R6, R2 (no EE appears)
        for (int i = 0; i < 16; i++) begin
            check("R6 order", 32'(cmd_byte), 32'h10 + 32'(i));
            check("R2 flags clear", 32'(cmd_kind), 0);
            cycle(1'b0, '0, 1'b1, 1'b0);
        end
        check("R6 drained", 32'(cmd_valid), 0);

        // R10 simultaneous push and pop
        cycle(1'b1, 32'h21, 1'b0, 1'b0);
        cycle(1'b1, 32'h22, 1'b0, 1'b0);
        cycle(1'b1, 32'h23, 1'b1, 1'b0);
        check("R10 level", 32'(level), 2);
        check("R10 head", 32'(cmd_byte), 32'h22);
        cycle(1'b0, '0, 1'b1, 1'b0);
        check("R10 order", 32'(cmd_byte), 32'h23);

        // R7 flush beats push and pop
        cycle(1'b1, 32'h31, 1'b1, 1'b1);
        check("R7 level", 32'(level), 0);
        check("R7 empty", 32'(empty), 1);
        check("R7 cmd_valid", 32'(cmd_valid), 0);

        // R8 head byte survives reset
        cycle(1'b1, 32'h0000_035A, 1'b0, 1'b0);
        check("R8 pre-reset", rd_word, 32'h5A);
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 kept byte", rd_word, 32'h5A);
        check("R8 level", 32'(level), 0);
        check("R8 valid", 32'(cmd_valid), 0);
        check("R8 stop clear", 32'(cmd_stop), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule